// File: doc/BRIEF.md
# I2C Master Interrupt Status Unit

This unit keeps the interrupt state of an I2C master controller. Twelve event inputs from the controller's datapath feed a raw status vector. Most bits are sticky, and two bits are level-type and follow their input. A software-visible mask register gates the raw vector into a masked status, and any masked bit drives a single interrupt line. Software clears bits through read side effects. Each source has its own clear address, and one extra address clears every sticky bit at once.

When the controller reports a transmit abort, the unit also latches a vector that says why. The vector stays readable until software reads the abort's own clear address. The same abort event raises a one-cycle flush request toward the transmit and receive FIFOs.

Register access goes through a plain address, read strobe and write strobe port. Read data is combinational from the address. Every side effect takes place at the clock edge that ends the read or write cycle.

Top module: `i2c_irq_unit`

## Requirements
- R1: Raw status bit order: 0 rx_under, 1 rx_over, 2 rx_full, 3 tx_over, 4 tx_empty, 5 rd_req, 6 tx_abrt, 7 rx_done, 8 activity, 9 stop_det, 10 start_det, 11 gen_call. A one on a sticky event input sets its raw bit at the next edge. The bit then holds until it is cleared. The raw vector reads at address 0x00.
- R2: Bits 2 (rx_full) and 4 (tx_empty) are level-type. Each cycle they take the value of their event input. Clear reads do not change them.
- R3: Masked status reads at address 0x01 and equals the raw vector AND the mask. irq_o is high exactly when some masked bit is set.
- R4: The mask register sits at address 0x02. It resets to 0x254 (bits 2, 4, 6 and 9 enabled), and a write there replaces it.
- R5: A read strobe at address 0x10+i clears sticky raw bit i only, for i = 0..11. Clear reads return 0.
- R6: A read strobe at address 0x08 clears every sticky raw bit.
- R7: When an event and a clear read of the same bit fall in one cycle, the bit ends up set.
- R8: An abort event ORs abort_cause_i into the cause vector at address 0x03. Cause bit meanings:
  - 0: 7-bit address NACK
  - 1 and 2: 10-bit first and second address byte NACK
  - 3: data NACK
  - 4: general-call NACK
  - 5: general-call read
  - 7: start byte acknowledged
  - 9: start byte with restart off
  - 10: 10-bit read with restart off
  - 11: use while disabled
  - 12: arbitration lost

  Bits 6 and 8 always read 0.
- R9: The cause vector is cleared only by a read strobe at the abort clear address 0x16. The global clear leaves it unchanged.
- R10: flush_o is high in the cycle after each cycle with ev_i[6] high, and low otherwise.
- R11: Reads of status addresses, and writes to any address other than 0x02, leave the raw vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | 12 | Event inputs, one per status bit |
| abort_cause_i | input | 13 | Abort reasons, sampled with ev_i[6] |
| addr_i | input | 5 | Register address |
| rd_en_i | input | 1 | Read strobe (triggers clear side effects) |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 12 | Write data (mask value) |
| rd_data_o | output | 16 | Combinational read data |
| irq_o | output | 1 | Interrupt request |
| flush_o | output | 1 | FIFO flush pulse on abort |

## Verification
The sticky path is tested with one multi-bit event pattern, followed by a per-source clear and then a global clear. This shows whether a clear reaches only its own bit or spills onto its neighbours. A held level input, combined with a clear read of that bit, distinguishes level-type behaviour from sticky behaviour. An event that coincides with its own clear read checks the set-wins priority.

Two successive aborts carry different cause patterns, and the second pattern includes the reserved bits. This shows accumulation by OR and the filtering of reserved bits. A global clear followed by an abort clear shows that only the abort clear address wipes the cause vector. Mask writes of a single bit and of zero show how irq_o tracks the masked status.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int NUM_SRC = 12;
    localparam int CAUSE_W = 13;

    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 4;
    localparam int SRC_TX_ABRT  = 6;

    localparam logic [NUM_SRC-1:0] LEVEL_SRC  = (NUM_SRC'(1) << SRC_RX_FULL) |
                                                (NUM_SRC'(1) << SRC_TX_EMPTY);
    localparam logic [NUM_SRC-1:0] MASK_RESET = 12'h254;
    // bits 6 and 8 of the cause vector carry no meaning
    localparam logic [CAUSE_W-1:0] CAUSE_VALID = 13'h1EBF;

    localparam int A_RAW     = 'h00;
    localparam int A_MASKED  = 'h01;
    localparam int A_MASK    = 'h02;
    localparam int A_CAUSE   = 'h03;
    localparam int A_CLR_ALL = 'h08;
    localparam int A_CLR_BASE = 'h10;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_RAW,
        SEL_MASKED,
        SEL_MASK,
        SEL_CAUSE
    } rsel_e;

    function automatic rsel_e decode_sel(input int a);
        case (a)
            A_RAW:    return SEL_RAW;
            A_MASKED: return SEL_MASKED;
            A_MASK:   return SEL_MASK;
            A_CAUSE:  return SEL_CAUSE;
            default:  return SEL_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic               clr_cause_o,
    output logic [DATA_W-1:0]  rd_data_o
);

    logic  clr_all;
    rsel_e sel;

    assign clr_all = rd_en_i && (addr_i == ADDR_W'(A_CLR_ALL));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        assign clr_o[i] = clr_all ||
                          (rd_en_i && (addr_i == ADDR_W'(A_CLR_BASE + i)));
    end

    assign clr_cause_o = rd_en_i && (addr_i == ADDR_W'(A_CLR_BASE + SRC_TX_ABRT));

    always_ff @(posedge clk) begin
        if (rst)
            mask_o <= MASK_RESET;
        else if (wr_en_i && (addr_i == ADDR_W'(A_MASK)))
            mask_o <= wr_data_i;
    end

    assign sel = decode_sel(int'(addr_i));

    always_comb begin
        rd_data_o = '0;
        case (sel)
            SEL_RAW:    rd_data_o = DATA_W'(raw_i);
            SEL_MASKED: rd_data_o = DATA_W'(raw_i & mask_o);
            SEL_MASK:   rd_data_o = DATA_W'(mask_o);
            SEL_CAUSE:  rd_data_o = DATA_W'(cause_i);
            default:    rd_data_o = '0;
        endcase
    end

    p_mask_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADDR_W'(A_MASK)) |=> (mask_o == $past(wr_data_i)));

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && addr_i == ADDR_W'(A_MASK)) |=> $stable(mask_o));

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] raw_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (LEVEL_SRC[i]) begin : g_level
            always_ff @(posedge clk) begin
                if (rst) raw_o[i] <= 1'b0;
                else     raw_o[i] <= ev_i[i];
            end

            p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (raw_o[i] == $past(ev_i[i])));
        end else begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst) raw_o[i] <= 1'b0;
                else     raw_o[i] <= (raw_o[i] && !clr_i[i]) || ev_i[i];
            end

            p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
                ev_i[i] |=> raw_o[i]);

            p_clear_r5: assert property (@(posedge clk) disable iff (rst)
                (clr_i[i] && !ev_i[i]) |=> !raw_o[i]);

            p_hold_r1: assert property (@(posedge clk) disable iff (rst)
                (!clr_i[i] && !ev_i[i]) |=> $stable(raw_o[i]));
        end
    end

endmodule

// File: rtl/i2c_irq_abort.sv
module i2c_irq_abort
    import i2c_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               abort_ev_i,
    input  logic [CAUSE_W-1:0] cause_in_i,
    input  logic               clr_cause_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               flush_o
);

    logic [CAUSE_W-1:0] cause_new;

    assign cause_new = abort_ev_i ? (cause_in_i & CAUSE_VALID) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_o <= '0;
            flush_o <= 1'b0;
        end else begin
            cause_o <= (clr_cause_i ? '0 : cause_o) | cause_new;
            flush_o <= abort_ev_i;
        end
    end

    p_cause_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr_cause_i && !abort_ev_i) |=> $stable(cause_o));

    p_cause_accum_r8: assert property (@(posedge clk) disable iff (rst)
        (abort_ev_i && !clr_cause_i) |=>
        ((cause_o & $past(cause_o)) == $past(cause_o)));

    p_flush_on_r10: assert property (@(posedge clk) disable iff (rst)
        abort_ev_i |=> flush_o);

    p_flush_off_r10: assert property (@(posedge clk) disable iff (rst)
        !abort_ev_i |=> !flush_o);

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic [CAUSE_W-1:0] abort_cause_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_o,
    output logic               flush_o
);

    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] clr;
    logic               clr_cause;
    logic [CAUSE_W-1:0] cause;

    i2c_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk         (clk),
        .rst         (rst),
        .addr_i      (addr_i),
        .rd_en_i     (rd_en_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .raw_i       (raw),
        .cause_i     (cause),
        .mask_o      (mask),
        .clr_o       (clr),
        .clr_cause_o (clr_cause),
        .rd_data_o   (rd_data_o)
    );

    i2c_irq_status u_status (
        .clk   (clk),
        .rst   (rst),
        .ev_i  (ev_i),
        .clr_i (clr),
        .raw_o (raw)
    );

    i2c_irq_abort u_abort (
        .clk         (clk),
        .rst         (rst),
        .abort_ev_i  (ev_i[SRC_TX_ABRT]),
        .cause_in_i  (abort_cause_i),
        .clr_cause_i (clr_cause),
        .cause_o     (cause),
        .flush_o     (flush_o)
    );

    assign irq_o = |(raw & mask);

    p_flush_pending_r10: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> raw[SRC_TX_ABRT]);

    p_irq_needs_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_o);

endmodule

// File: tb/i2c_irq_unit_tb.sv
`timescale 1ns/1ps
module i2c_irq_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ev_i = '0;
    logic [12:0] abort_cause_i = '0;
    logic [4:0]  addr_i = '0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [11:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        irq_o;
    logic        flush_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    i2c_irq_unit u_dut (
        .clk(clk), .rst(rst), .ev_i(ev_i), .abort_cause_i(abort_cause_i),
        .addr_i(addr_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
        .flush_o(flush_o)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // read with side effect; data sampled inside the strobe cycle
    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        #1 d = rd_data_o;
        @(negedge clk);
        rd_en_i = 1'b0; addr_i = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [11:0] v);
        @(negedge clk);
        addr_i = a; wr_data_i = v; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; addr_i = '0;
    endtask

    task automatic pulse(input logic [11:0] v, input logic [12:0] c);
        @(negedge clk);
        ev_i = v; abort_cause_i = c;
        @(negedge clk);
        ev_i = '0; abort_cause_i = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R4 reset irq", {15'd0, irq_o}, 16'd0);
        chk("R10 reset flush", {15'd0, flush_o}, 16'd0);
        rd(5'h00, d); chk("R1 reset raw", d, 16'h0000);
        rd(5'h02, d); chk("R4 reset mask", d, 16'h0254);
        rd(5'h03, d); chk("R8 reset cause", d, 16'h0000);
    endtask

    task automatic t_sticky();
        logic [15:0] d;
        pulse(12'hFAB, '0);
        rd(5'h00, d); chk("R1 sticky set", d, 16'h0FAB);
        rd(5'h00, d); chk("R11 status read no clear", d, 16'h0FAB);
        rd(5'h13, d); chk("R5 clear read data", d, 16'h0000);
        rd(5'h00, d); chk("R5 clear only bit 3", d, 16'h0FA3);
        rd(5'h01, d); chk("R3 masked", d, 16'h0200);
        chk("R3 irq high", {15'd0, irq_o}, 16'd1);
        rd(5'h08, d);
        rd(5'h00, d); chk("R6 global clear", d, 16'h0000);
        chk("R3 irq low", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_write_no_effect();
        logic [15:0] d;
        pulse(12'h008, '0);
        wr(5'h13, 12'hFFF);
        wr(5'h08, 12'hFFF);
        rd(5'h00, d); chk("R11 write to clear addr ignored", d, 16'h0008);
        rd(5'h02, d); chk("R11 mask untouched", d, 16'h0254);
        rd(5'h13, d);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        wr(5'h02, 12'h001);
        rd(5'h02, d); chk("R4 mask write", d, 16'h0001);
        pulse(12'h001, '0);
        rd(5'h01, d); chk("R3 masked single", d, 16'h0001);
        chk("R3 irq single", {15'd0, irq_o}, 16'd1);
        wr(5'h02, 12'h000);
        chk("R3 irq masked off", {15'd0, irq_o}, 16'd0);
        rd(5'h01, d); chk("R3 masked zero", d, 16'h0000);
        rd(5'h00, d); chk("R3 raw keeps bit", d, 16'h0001);
        wr(5'h02, 12'h254);
        rd(5'h08, d);
    endtask

    task automatic t_level();
        logic [15:0] d;
        @(negedge clk); ev_i = 12'h004;
        @(negedge clk);
        addr_i = 5'h12; rd_en_i = 1'b1;
        @(negedge clk); rd_en_i = 1'b0; addr_i = '0;
        @(negedge clk);
        addr_i = 5'h00; #1 d = rd_data_o;
        chk("R2 level held after clear", d, 16'h0004);
        ev_i = '0;
        @(negedge clk);
        #1 d = rd_data_o;
        chk("R2 level follows release", d, 16'h0000);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        pulse(12'h200, '0);
        @(negedge clk);
        ev_i = 12'h200; addr_i = 5'h19; rd_en_i = 1'b1;
        @(negedge clk);
        ev_i = '0; rd_en_i = 1'b0; addr_i = '0;
        rd(5'h00, d); chk("R7 set wins", d, 16'h0200);
        rd(5'h19, d);
        rd(5'h00, d); chk("R5 clear after set", d, 16'h0000);
    endtask

    task automatic t_abort();
        logic [15:0] d;
        @(negedge clk);
        ev_i = 12'h040; abort_cause_i = 13'h0009;
        @(negedge clk);
        ev_i = '0; abort_cause_i = '0;
        chk("R10 flush pulse", {15'd0, flush_o}, 16'd1);
        @(negedge clk);
        chk("R10 flush ends", {15'd0, flush_o}, 16'd0);
        rd(5'h03, d); chk("R8 cause latched", d, 16'h0009);
        pulse(12'h040, 13'h1140);
        rd(5'h03, d); chk("R8 accumulate, reserved dropped", d, 16'h1009);
        rd(5'h08, d);
        rd(5'h00, d); chk("R6 abort bit cleared", d, 16'h0000);
        rd(5'h03, d); chk("R9 cause survives global clear", d, 16'h1009);
        rd(5'h16, d);
        rd(5'h03, d); chk("R9 cause cleared", d, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sticky();
        t_write_no_effect();
        t_mask();
        t_level();
        t_set_wins();
        t_abort();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule